// File: doc/BRIEF.md
# Soft-Symbol and Variance Generator

This block sits in the detector of an iterative multi-antenna receiver. For one spatial stream it takes the a-priori bit log-likelihood ratios (LLRs) fed back by the channel decoder and produces the mean of the transmitted constellation point (the soft symbol) and the variance of that point around the mean. The interference canceller that follows uses both values. No hard decision is made anywhere: a bit with a zero LLR contributes its full uncertainty, and a bit with a very large LLR pins its part of the symbol.

Each LLR is mapped to a signed bit reliability t = tanh(L/2) by a small table. Square QAM with Gray labels splits into two independent PAM axes, so the block evaluates the first and second moments of each axis in closed form from the t values of that axis. It then combines the axes into a complex mean and a total variance. The datapath has two pipeline stages with a valid/ready handshake on both sides. Once full, it accepts one stream per clock.

Top module: `soft_symbol_gen`

## Requirements
- R1: While reset is held and directly after it, out_valid is 0 and in_ready is 1.
- R2: Each 8-bit two's-complement LLR lane carries 2 fractional bits. Its reliability is t = sign(L)·round(256·tanh(min(|L|,63)/8))/256, and bit value 1 has probability (1+t)/2. For BPSK, out_re equals t exactly.
- R3: in_mod selects the format: 0 BPSK, 1 QPSK, 2 16-QAM, 3 64-QAM. The real axis takes lanes 0..n-1 and the imaginary axis takes the next n lanes, with n = 1, 1, 2, 3 and no imaginary axis for BPSK. On an axis, the first lane is the sign bit (1 = positive). Magnitude labels are: for 2 bits, second bit 1→1 and 0→3; for 3 bits, (second, third) 10→1, 11→3, 01→5, 00→7.
- R4: out_re and out_im are signed with 8 fractional bits. Each is within 1/32 of the probability-weighted sum of the constellation points, with each point weighted by the product of its bit probabilities.
- R5: out_var is unsigned with 8 fractional bits and is never below zero. It is within 1/4 of the expected squared distance from the soft symbol, and never exceeds 98.
- R6: With all used LLRs zero, the soft symbol is exactly 0 and the variance is exactly 1, 2, 10 or 42 for BPSK, QPSK, 16-QAM and 64-QAM.
- R7: With every used LLR at magnitude 64 or more (including -128), the output is exactly the labelled constellation point and the variance is exactly 0.
- R8: Lanes not used by the selected format have no effect. For BPSK, out_im is exactly 0.
- R9: A result appears 2 cycles after its input is accepted when out_ready stays high, and back-to-back inputs are accepted on consecutive cycles.
- R10: While out_valid is 1 and out_ready is 0, the outputs hold their values and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input stream present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_mod | input | 2 | Modulation select |
| in_llr | input | 48 | Six LLR lanes, lane k at bits 8k+7..8k |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_re | output | 12 | Real part of soft symbol |
| out_im | output | 12 | Imaginary part of soft symbol |
| out_var | output | 15 | Symbol variance |

## Verification
Two things can happen in the same cycle: a new stream enters stage one while the finished result is held at the output, or the result leaves while another is accepted. To provoke both, the bench drives inputs back-to-back with mixed modulations while out_ready follows a pseudo-random pattern. Each popped result is judged against a scoreboard model that enumerates every constellation point. Across each stall, the held output values and the low in_ready are checked.

// File: rtl/soft_symbol_gen.sv
module soft_symbol_gen #(
  parameter int LLR_W  = 8,
  parameter int LLR_F  = 2,
  parameter int LUT_AW = 6,
  parameter int TF     = 8,
  localparam int NL    = 6,
  localparam int SYM_W = TF + 4,
  localparam int VAR_W = TF + 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_mod,
  input  logic [NL*LLR_W-1:0]   in_llr,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SYM_W-1:0]      out_re,
  output logic [SYM_W-1:0]      out_im,
  output logic [VAR_W-1:0]      out_var
);
  localparam int ONE   = 1 << TF;
  localparam int LUT_N = 1 << LUT_AW;
  localparam int TW    = TF + 2;

  function automatic int tanh_q(input int k);
    real x, e;
    x = real'(k) / real'(1 << (LLR_F + 1));
    e = $exp(-2.0 * x);
    return $rtoi(real'(ONE) * (1.0 - e) / (1.0 + e) + 0.5);
  endfunction

  function automatic logic [63:0] axis(input int nb, input int a, input int b, input int c);
    int m, s, em;
    if (nb == 1) begin
      m = a;
      s = ONE;
    end else if (nb == 2) begin
      m = (a * (2 * ONE - b)) >>> TF;
      s = 5 * ONE - 4 * b;
    end else begin
      em = (4 * ONE * ONE - b * (2 * ONE - c)) >>> TF;
      m  = (a * em) >>> TF;
      s  = 21 * ONE - 16 * b - 4 * c + ((b * c) >>> (TF - 3));
    end
    return {m, s};
  endfunction

  logic [TW-1:0]        lut [LUT_N];
  logic signed [TW-1:0] tn  [NL];
  logic signed [TW-1:0] t1  [NL];
  logic                 adv, v1, v2;
  logic [1:0]           mod1;
  logic [63:0]          ai, aq;
  int                   mi, si, mq, sq, vv;
  logic [SYM_W-1:0]     re2, im2;
  logic [VAR_W-1:0]     var2;

  assign adv      = !v2 || out_ready;
  assign in_ready = adv;

  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    localparam int TV = tanh_q(k);
    assign lut[k] = TW'(TV);
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic signed [LLR_W-1:0] l;
    logic [LLR_W:0]          mag;
    logic [LUT_AW-1:0]       addr;
    assign l    = in_llr[k*LLR_W +: LLR_W];
    assign mag  = l[LLR_W-1] ? -{l[LLR_W-1], l} : {1'b0, l};
    assign addr = (mag > (LLR_W+1)'(LUT_N - 1)) ? LUT_AW'(LUT_N - 1) : mag[LUT_AW-1:0];
    assign tn[k] = l[LLR_W-1] ? -$signed(lut[addr]) : $signed(lut[addr]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1 <= 1'b0;
    else if (adv) begin
      v1   <= in_valid;
      mod1 <= in_mod;
      for (int k = 0; k < NL; k++) t1[k] <= tn[k];
    end
  end

  always_comb begin
    case (mod1)
      2'd0: begin
        ai = axis(1, int'(t1[0]), 0, 0);
        aq = '0;
      end
      2'd1: begin
        ai = axis(1, int'(t1[0]), 0, 0);
        aq = axis(1, int'(t1[1]), 0, 0);
      end
      2'd2: begin
        ai = axis(2, int'(t1[0]), int'(t1[1]), 0);
        aq = axis(2, int'(t1[2]), int'(t1[3]), 0);
      end
      default: begin
        ai = axis(3, int'(t1[0]), int'(t1[1]), int'(t1[2]));
        aq = axis(3, int'(t1[3]), int'(t1[4]), int'(t1[5]));
      end
    endcase
    mi = ai[63:32];
    si = ai[31:0];
    mq = aq[63:32];
    sq = aq[31:0];
    vv = si - ((mi * mi) >>> TF) + sq - ((mq * mq) >>> TF);
    if (vv < 0) vv = 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2 <= 1'b0;
    else if (adv) begin
      v2   <= v1;
      re2  <= SYM_W'(mi);
      im2  <= SYM_W'(mq);
      var2 <= VAR_W'(vv);
    end
  end

  assign out_valid = v2;
  assign out_re    = re2;
  assign out_im    = im2;
  assign out_var   = var2;
endmodule

// File: rtl/soft_symbol_gen_chk.sv
module soft_symbol_gen_chk #(
  parameter int SYM_W = 12,
  parameter int VAR_W = 15,
  parameter int TF    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SYM_W-1:0] out_re,
  input logic [SYM_W-1:0] out_im,
  input logic [VAR_W-1:0] out_var
);
  localparam int LIM  = 7 << TF;
  localparam int VMAX = 98 << TF;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_var));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  p_sym_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'($signed(out_re)) <= LIM && int'($signed(out_re)) >= -LIM &&
                  int'($signed(out_im)) <= LIM && int'($signed(out_im)) >= -LIM);

  p_var_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_var) <= VMAX);
endmodule

bind soft_symbol_gen soft_symbol_gen_chk #(.SYM_W(SYM_W), .VAR_W(VAR_W), .TF(TF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_re(out_re), .out_im(out_im), .out_var(out_var)
);

// File: tb/test_soft_symbol_gen.sv
module test_soft_symbol_gen;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [1:0]  in_mod = 0;
  logic [47:0] in_llr = '0;
  logic        in_ready, out_valid;
  logic [11:0] out_re, out_im;
  logic [14:0] out_var;

  always #2 clk = ~clk;

  soft_symbol_gen i_soft_symbol_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mod(in_mod), .in_llr(in_llr), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_var(out_var));

  typedef struct {real re; real im; real vr; real tr; real tv; int acc; string ts; string tg;} item_t;
  item_t q[$];
  int checks = 0, errors = 0, cyc = 0, rmode = 0;
  int lv[6];
  logic [7:0] lf = 8'h5a;
  bit done = 0, stalled = 0;
  logic [11:0] s_re, s_im;
  logic [14:0] s_var;

  always @(posedge clk) cyc++;

  function automatic real rabs(input real x);
    return x < 0.0 ? -x : x;
  endfunction

  function automatic real tq(input int l);
    int a;
    real x, e;
    a = l < 0 ? -l : l;
    if (a > 63) a = 63;
    x = a / 8.0;
    e = $exp(-2.0 * x);
    return (l < 0 ? -1.0 : 1.0) * $rtoi(256.0 * (1.0 - e) / (1.0 + e) + 0.5) / 256.0;
  endfunction

  function automatic int lvl(input int nb, input int bits);
    int sg, mg, b1, b2;
    sg = (bits & 1) ? 1 : -1;
    b1 = (bits >> 1) & 1;
    b2 = (bits >> 2) & 1;
    if (nb == 1) mg = 1;
    else if (nb == 2) mg = b1 ? 1 : 3;
    else mg = b1 ? (b2 ? 3 : 1) : (b2 ? 5 : 7);
    return sg * mg;
  endfunction

  task automatic axis_model(input int nb, input real t0, input real t1, input real t2,
                            output real m, output real s);
    real tt[3];
    tt[0] = t0; tt[1] = t1; tt[2] = t2;
    m = 0.0; s = 0.0;
    for (int bits = 0; bits < (1 << nb); bits++) begin
      real p;
      int x;
      p = 1.0;
      for (int k = 0; k < nb; k++)
        p = p * ((((bits >> k) & 1) != 0) ? (1.0 + tt[k]) / 2.0 : (1.0 - tt[k]) / 2.0);
      x = lvl(nb, bits);
      m = m + p * x;
      s = s + p * x * x;
    end
  endtask

  task automatic send(input int mod, input string ts, input string tg, input real tr, input real tv);
    item_t it;
    int ni, nq;
    real mi, si, mq, sq;
    ni = (mod < 2) ? 1 : (mod == 2) ? 2 : 3;
    nq = (mod == 0) ? 0 : ni;
    axis_model(ni, tq(lv[0]), ni > 1 ? tq(lv[1]) : 0.0, ni > 2 ? tq(lv[2]) : 0.0, mi, si);
    if (nq > 0)
      axis_model(nq, tq(lv[ni]), nq > 1 ? tq(lv[ni+1]) : 0.0, nq > 2 ? tq(lv[ni+2]) : 0.0, mq, sq);
    else begin
      mq = 0.0; sq = 0.0;
    end
    it.re = mi; it.im = mq; it.vr = (si - mi * mi) + (sq - mq * mq);
    it.tr = tr; it.tv = tv; it.ts = ts; it.tg = tg;
    @(negedge clk);
    in_valid = 1;
    in_mod = 2'(mod);
    for (int k = 0; k < 6; k++) in_llr[k*8 +: 8] = 8'(lv[k]);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.acc = cyc;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 0;
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic report();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always begin
    @(negedge clk);
    if (rmode == 1) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = lf[0] | lf[2];
    end else out_ready = 1;
    #1;
    if (rst_n && !done) begin
      if (stalled) begin
        checks++;
        if (!out_valid || out_re != s_re || out_im != s_im || out_var != s_var) begin
          errors++;
          $display("FAIL R10 held output changed: valid %0d re %0d im %0d var %0d expected 1 %0d %0d %0d",
                   out_valid, out_re, out_im, out_var, s_re, s_im, s_var);
        end
      end
      stalled = 0;
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R10 in_ready during stall: got %0d expected 0", in_ready);
        end
        stalled = 1;
        s_re = out_re; s_im = out_im; s_var = out_var;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected output: got valid 1 expected 0");
        end else begin
          item_t it;
          real ar, aim, av;
          it = q.pop_front();
          ar  = real'($signed(out_re)) / 256.0;
          aim = real'($signed(out_im)) / 256.0;
          av  = real'(out_var) / 256.0;
          checks++;
          if (rabs(ar - it.re) > it.tr || rabs(aim - it.im) > it.tr) begin
            errors++;
            $display("FAIL %s symbol: got %f %f expected %f %f", it.ts, ar, aim, it.re, it.im);
          end
          checks++;
          if (rabs(av - it.vr) > it.tv) begin
            errors++;
            $display("FAIL %s variance: got %f expected %f", it.tg, av, it.vr);
          end
          if (rmode == 0) begin
            checks++;
            if (cyc - it.acc != 2) begin
              errors++;
              $display("FAIL R9 latency: got %0d expected 2", cyc - it.acc);
            end
          end
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL R9 watchdog: got hang expected completion");
          report();
        end
      end
    join_none
  end

  initial begin
    int first, last;
    int hv[4];
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 in reset: got valid %0d ready %0d expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset: got valid %0d ready %0d expected 0 1", out_valid, in_ready);
    end

    // R2 and R8: BPSK reliability table, junk in unused lanes
    hv = '{1, 5, 20, 63};
    foreach (hv[i]) begin
      for (int sg = 0; sg < 2; sg++) begin
        lv[0] = sg ? -hv[i] : hv[i];
        for (int k = 1; k < 6; k++) lv[k] = $urandom_range(0, 255) - 128;
        send(0, "R2 R8", "R5", 0.0, 0.25);
      end
    end
    lv[0] = 0;  send(0, "R2 R8", "R5", 0.0, 0.25);
    lv[0] = 64; send(0, "R2 R8", "R5", 0.0, 0.25);
    lv[0] = 127; send(0, "R2 R8", "R5", 0.0, 0.25);
    lv[0] = -128; send(0, "R2 R8", "R5", 0.0, 0.25);

    // R6: zero LLRs, every format
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 6; k++) lv[k] = 0;
      send(m, "R6", "R6", 0.0, 0.0);
    end

    // R7 and R3: saturated LLRs give labelled points
    for (int p = 0; p < 64; p += 7) begin
      for (int k = 0; k < 6; k++) lv[k] = ((p >> k) & 1) ? 127 : (k % 2 ? -128 : -64);
      send(3, "R7 R3", "R7", 0.0, 0.0);
      send(2, "R7 R3", "R7", 0.0, 0.0);
      send(1, "R7 R3", "R7", 0.0, 0.0);
    end

    // R8: QPSK with junk in lanes 2..5
    for (int i = 0; i < 4; i++) begin
      lv[0] = 9 - 6 * i; lv[1] = -3 + 5 * i;
      for (int k = 2; k < 6; k++) lv[k] = $urandom_range(0, 255) - 128;
      send(1, "R8 R4", "R5", 1.0 / 32, 0.25);
    end

    // R9: back-to-back throughput
    for (int i = 0; i < 20; i++) begin
      for (int k = 0; k < 6; k++) lv[k] = $urandom_range(0, 255) - 128;
      send(3, "R4 R3", "R5", 1.0 / 32, 0.25);
      if (i == 0) first = cyc;
      last = cyc;
    end
    checks++;
    if (last - first != 19) begin
      errors++;
      $display("FAIL R9 throughput: got %0d cycles expected 19", last - first);
    end
    drain();

    // R4 R5 R10: mixed formats with random back-pressure
    rmode = 1;
    for (int i = 0; i < 80; i++) begin
      for (int k = 0; k < 6; k++) lv[k] = $urandom_range(0, 60) - 30;
      send(i % 4, "R4", "R5", 1.0 / 32, 0.25);
    end
    drain();
    rmode = 0;
    repeat (4) @(posedge clk);
    report();
  end
endmodule